// File: doc/BRIEF.md
# Four-Candidate SAD Accumulator

This block scores four candidate reference blocks against one shared source block by summing absolute pixel differences. All four sums are built in a single pass. Pixels arrive row by row on a streaming input with a valid/ready handshake. Each beat carries 16 source pixels, the matching 16 pixels of each of the four references and 16 pixels of a second prediction. Addressing, strides and the choice of the winning candidate stay outside the block.

A start pulse latches the block size and two mode flags. With compound mode on, each reference pixel is first replaced by its rounded average with the second-prediction pixel, and that same pixel serves all four candidates. With skip-rows mode on, the caller still streams every row, but only even rows count and each final sum is doubled. One cycle after the last beat, a done pulse appears and the four results become valid. The results then hold until the next accepted start.

Top module: `quad_sad_engine`

## Requirements
- R1: Pixels are unsigned 8-bit, with lane i on bits [8i+7:8i] of each bus. Result `sum_k` (k = 0..3) is the sum over the block of |src - cand_k|, reported as 32 bits.
- R2: Size codes 0..5 select 4, 8, 16, 32, 64 or 128 pixels for both width and height. A row takes max(1, W/16) beats, with lane i of beat b holding column 16b+i. For W below 16, lanes i >= W are ignored.
- R3: When `cfg_avg` is 1, each candidate pixel c is replaced by (c + pred + 1) >> 1 before the difference is taken, using the same pred pixel for all four candidates.
- R4: When `cfg_skip` is 1, rows 1, 3, 5 and so on are accepted but not accumulated, and each reported sum is twice the accumulated value.
- R5: A start with `cfg_skip` = 1 and height code 0, or with either size code above 5, is rejected. `err` is high for the one following cycle, `busy` stays low, no done follows and the previous sums are kept.
- R6: A start while idle latches the configuration, clears the sums and raises `busy` in the next cycle. A start while busy is ignored.
- R7: `in_ready` is high exactly while busy. `done` is a one-cycle pulse in the cycle after the last beat is accepted, and `busy` falls in that same cycle. Cycles with `in_valid` low leave the sums untouched.
- R8: After reset, busy, done, err and all sums are 0. After done, the sums hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (sampled while idle) |
| cfg_wcode | input | 3 | Width code, W = 4 << code |
| cfg_hcode | input | 3 | Height code, H = 4 << code |
| cfg_avg | input | 1 | Compound averaging with the second prediction |
| cfg_skip | input | 1 | Accumulate even rows only, then double |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| src_px | input | 128 | Source pixels, 16 lanes |
| cand0_px | input | 128 | Candidate 0 pixels |
| cand1_px | input | 128 | Candidate 1 pixels |
| cand2_px | input | 128 | Candidate 2 pixels |
| cand3_px | input | 128 | Candidate 3 pixels |
| pred_px | input | 128 | Second-prediction pixels |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse, results valid |
| err | output | 1 | One-cycle pulse, start rejected |
| sum0 | output | 32 | Result for candidate 0 |
| sum1 | output | 32 | Result for candidate 1 |
| sum2 | output | 32 | Result for candidate 2 |
| sum3 | output | 32 | Result for candidate 3 |

## Verification
Blocks narrower than 16 pixels carry nonzero junk in the unused lanes, so a design that fails to mask those lanes reports sums that are too large. Skip-rows runs put full data on the odd rows, which exposes any design that adds those rows or forgets the final doubling. An all-zero source against saturated candidates with a zero prediction gives an averaged value of exactly 128, so a design that truncates instead of rounding reports 127 per pixel. Further directed cases cover:
- gapped input carrying a stray start, which catches sums corrupted by idle beats or a reconfiguration while busy;
- the 4-row skip request and the invalid size codes, which must raise the error flag and produce no done;
- the timing of the done pulse, which catches a pulse that comes late or lasts more than one cycle.

// File: rtl/quad_sad_engine.sv
module quad_sad_engine #(
  parameter int LANES   = 16,
  parameter int PIXW    = 8,
  parameter int SUMW    = 32,
  parameter int CODEW   = 3,
  parameter int MAXCODE = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CODEW-1:0]       cfg_wcode,
  input  logic [CODEW-1:0]       cfg_hcode,
  input  logic                   cfg_avg,
  input  logic                   cfg_skip,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIXW-1:0]  src_px,
  input  logic [LANES*PIXW-1:0]  cand0_px,
  input  logic [LANES*PIXW-1:0]  cand1_px,
  input  logic [LANES*PIXW-1:0]  cand2_px,
  input  logic [LANES*PIXW-1:0]  cand3_px,
  input  logic [LANES*PIXW-1:0]  pred_px,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [SUMW-1:0]        sum0,
  output logic [SUMW-1:0]        sum1,
  output logic [SUMW-1:0]        sum2,
  output logic [SUMW-1:0]        sum3
);
  localparam int NCAND   = 4;
  localparam int BUSW    = LANES * PIXW;
  localparam int MAXDIM  = 4 << MAXCODE;
  localparam int ROWW    = $clog2(MAXDIM);
  localparam int BEATW   = $clog2(MAXDIM / LANES + 1) + 1;

  logic [CODEW-1:0] wcode_q, hcode_q;
  logic             avg_q, skip_q;
  logic [ROWW-1:0]  row_q;
  logic [BEATW-1:0] beat_q;
  logic [SUMW-1:0]  acc [NCAND];
  logic [SUMW-1:0]  beat_sum [NCAND];
  logic [BUSW-1:0]  cand [NCAND];
  logic [LANES-1:0] lane_on;
  logic [BEATW-1:0] beat_last;
  logic [ROWW-1:0]  row_last;
  logic             cfg_ok, take, last_beat;

  assign cand[0] = cand0_px;
  assign cand[1] = cand1_px;
  assign cand[2] = cand2_px;
  assign cand[3] = cand3_px;

  assign cfg_ok = (int'(cfg_wcode) <= MAXCODE) && (int'(cfg_hcode) <= MAXCODE)
                  && !(cfg_skip && cfg_hcode == '0);
  assign in_ready = busy;
  assign take = busy && in_valid;

  always_comb begin
    int w;
    w = 4 << wcode_q;
    beat_last = (w > LANES) ? BEATW'(w / LANES - 1) : '0;
    row_last  = ROWW'((4 << hcode_q) - 1);
    for (int i = 0; i < LANES; i++) lane_on[i] = (i < w);
  end

  assign last_beat = (beat_q == beat_last) && (row_q == row_last);

  always_comb begin
    logic [PIXW-1:0] s, c, p, e, d;
    logic [PIXW:0]   avg;
    for (int k = 0; k < NCAND; k++) begin
      beat_sum[k] = '0;
      for (int i = 0; i < LANES; i++) begin
        s   = src_px[i*PIXW +: PIXW];
        c   = cand[k][i*PIXW +: PIXW];
        p   = pred_px[i*PIXW +: PIXW];
        avg = ({1'b0, c} + {1'b0, p} + 1'b1) >> 1;
        e   = avg_q ? avg[PIXW-1:0] : c;
        d   = (s > e) ? s - e : e - s;
        if (lane_on[i]) beat_sum[k] = beat_sum[k] + SUMW'(d);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      wcode_q <= '0;
      hcode_q <= '0;
      avg_q   <= 1'b0;
      skip_q  <= 1'b0;
      row_q   <= '0;
      beat_q  <= '0;
      for (int k = 0; k < NCAND; k++) acc[k] <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy && start) begin
        if (cfg_ok) begin
          busy    <= 1'b1;
          wcode_q <= cfg_wcode;
          hcode_q <= cfg_hcode;
          avg_q   <= cfg_avg;
          skip_q  <= cfg_skip;
          row_q   <= '0;
          beat_q  <= '0;
          for (int k = 0; k < NCAND; k++) acc[k] <= '0;
        end else begin
          err <= 1'b1;
        end
      end else if (take) begin
        if (!skip_q || !row_q[0])
          for (int k = 0; k < NCAND; k++) acc[k] <= acc[k] + beat_sum[k];
        if (last_beat) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (beat_q == beat_last) begin
          beat_q <= '0;
          row_q  <= row_q + 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign sum0 = skip_q ? acc[0] << 1 : acc[0];
  assign sum1 = skip_q ? acc[1] << 1 : acc[1];
  assign sum2 = skip_q ? acc[2] << 1 : acc[2];
  assign sum3 = skip_q ? acc[3] << 1 : acc[3];
endmodule

// File: rtl/quad_sad_engine_chk.sv
module quad_sad_engine_chk #(
  parameter int SUMW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            in_ready,
  input logic            done,
  input logic            err,
  input logic            skip_q,
  input logic [SUMW-1:0] sum0,
  input logic [SUMW-1:0] sum1,
  input logic [SUMW-1:0] sum2,
  input logic [SUMW-1:0] sum3
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !in_ready)); // R7
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done)); // R5
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R6
  AST_SUMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum0) && $stable(sum1) && $stable(sum2) && $stable(sum3))); // R8
  AST_SKIP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && skip_q) |-> !(sum0[0] || sum1[0] || sum2[0] || sum3[0])); // R4
endmodule

bind quad_sad_engine quad_sad_engine_chk #(.SUMW(SUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .in_ready(in_ready),
  .done(done), .err(err), .skip_q(skip_q),
  .sum0(sum0), .sum1(sum1), .sum2(sum2), .sum3(sum3)
);

// File: tb/quad_sad_engine_tb.sv
module quad_sad_engine_tb;
  logic clk = 0, rst_n = 0, start = 0, cfg_avg = 0, cfg_skip = 0, in_valid = 0;
  logic [2:0] cfg_wcode = 0, cfg_hcode = 0;
  logic [127:0] src_px = 0, cand0_px = 0, cand1_px = 0, cand2_px = 0, cand3_px = 0, pred_px = 0;
  logic in_ready, busy, done, err;
  logic [31:0] sum0, sum1, sum2, sum3;
  int checks = 0, fails = 0;
  logic [31:0] expv [4];

  always #5 clk = ~clk;

  quad_sad_engine u_dut (.*);

  function automatic logic [7:0] px(int pat, int seed, int k, int r, int c);
    int unsigned x;
    if (pat == 1) return (k == 0 || k == 5) ? 8'd0 : 8'd255;
    x = (seed * 32'h9E3779B1) ^ (k * 32'h85EBCA77) ^ (r * 32'h27D4EB2F) ^ (c * 32'h165667B1);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x[7:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(int pat, int seed, int wc, int hc, bit avg, bit skip);
    int w = 4 << wc, h = 4 << hc;
    for (int k = 0; k < 4; k++) expv[k] = 0;
    for (int r = 0; r < h; r++) begin
      if (skip && r % 2 == 1) continue;
      for (int c = 0; c < w; c++)
        for (int k = 0; k < 4; k++) begin
          int s = px(pat, seed, 0, r, c);
          int e = px(pat, seed, k + 1, r, c);
          if (avg) e = (e + px(pat, seed, 5, r, c) + 1) >> 1;
          expv[k] += (s > e) ? s - e : e - s;
        end
    end
    if (skip) for (int k = 0; k < 4; k++) expv[k] = expv[k] << 1;
  endtask

  task automatic drive_beat(int pat, int seed, int r, int b);
    for (int i = 0; i < 16; i++) begin
      src_px[i*8 +: 8]   = px(pat, seed, 0, r, b*16 + i);
      cand0_px[i*8 +: 8] = px(pat, seed, 1, r, b*16 + i);
      cand1_px[i*8 +: 8] = px(pat, seed, 2, r, b*16 + i);
      cand2_px[i*8 +: 8] = px(pat, seed, 3, r, b*16 + i);
      cand3_px[i*8 +: 8] = px(pat, seed, 4, r, b*16 + i);
      pred_px[i*8 +: 8]  = px(pat, seed, 5, r, b*16 + i);
    end
  endtask

  // One block; gapped inserts idle cycles with junk and a stray start (R6, R7)
  task automatic run_block(int pat, int seed, int wc, int hc, bit avg, bit skip, bit gapped);
    int w = 4 << wc, h = 4 << hc;
    int bpr = (w > 16) ? w / 16 : 1;
    string tag;
    tag = avg ? (skip ? "R3/R4" : "R3") : (skip ? "R4" : (wc < 2 ? "R2" : "R1"));
    model(pat, seed, wc, hc, avg, skip);
    @(negedge clk);
    cfg_wcode = 3'(wc); cfg_hcode = 3'(hc); cfg_avg = avg; cfg_skip = skip; start = 1;
    @(negedge clk);
    start = 0;
    if (gapped) chk("R6 busy after start", {31'd0, busy}, 1);
    for (int r = 0; r < h; r++)
      for (int b = 0; b < bpr; b++) begin
        if (gapped && (b + r) % 3 == 0) begin
          in_valid = 0;
          drive_beat(0, seed + 77, r, b);
          start = 1; cfg_wcode = 0; cfg_hcode = 0; cfg_avg = ~avg; cfg_skip = 0;
          @(negedge clk);
          start = 0;
        end
        drive_beat(pat, seed, r, b);
        in_valid = 1;
        @(negedge clk);
      end
    in_valid = 0;
    chk("R7 done after last beat", {31'd0, done}, 1);
    chk("R7 busy low at done", {31'd0, busy}, 0);
    chk({tag, " sum0"}, sum0, expv[0]);
    chk({tag, " sum1"}, sum1, expv[1]);
    chk({tag, " sum2"}, sum2, expv[2]);
    chk({tag, " sum3"}, sum3, expv[3]);
    @(negedge clk);
    chk("R7 done single cycle", {31'd0, done}, 0);
  endtask

  task automatic hold_test();
    logic [31:0] s0 = sum0;
    repeat (6) @(negedge clk);
    chk("R8 sums hold after done", sum0, s0);
    chk("R8 sums hold after done sum3", sum3, expv[3]);
  endtask

  task automatic reject_test(int wc, int hc, bit skip);
    @(negedge clk);
    cfg_wcode = 3'(wc); cfg_hcode = 3'(hc); cfg_skip = skip; cfg_avg = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R5 err raised", {31'd0, err}, 1);
    chk("R5 busy stays low", {31'd0, busy}, 0);
    chk("R7 ready low while idle", {31'd0, in_ready}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 no done", {31'd0, done}, 0);
    end
    chk("R5 sums kept", sum2, expv[2]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", {31'd0, busy}, 0);
    chk("R8 reset done", {31'd0, done}, 0);
    chk("R8 reset err", {31'd0, err}, 0);
    chk("R8 reset sum0", sum0, 0);
    chk("R8 reset sum3", sum3, 0);
    rst_n = 1;
    // R1 R2 R3 R4: every size, every mode combination
    for (int wc = 0; wc <= 5; wc++)
      for (int hc = 0; hc <= 5; hc++)
        for (int m = 0; m < 4; m++) begin
          if (m[1] && hc == 0) continue;
          run_block(0, wc * 31 + hc * 7 + m, wc, hc, m[0], m[1], 0);
        end
    // R3 rounding at saturation: (255+0+1)>>1 = 128
    run_block(1, 0, 1, 1, 1, 0, 0);
    run_block(1, 0, 2, 0, 0, 0, 0);
    run_block(1, 0, 0, 2, 1, 1, 0);
    // R6 R7: gaps with stray starts while busy
    run_block(0, 901, 3, 1, 1, 0, 1);
    run_block(0, 902, 0, 2, 0, 1, 1);
    hold_test();
    // R5: rejected configurations
    reject_test(2, 0, 1);
    reject_test(6, 1, 0);
    reject_test(1, 7, 0);
    run_block(0, 903, 2, 1, 0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule